// File: doc/BRIEF.md
# Delay-Sampling Manchester Receiver

This block recovers serial data, a bit clock and whole bytes from a Manchester-coded line. In the coding used here, a 1 is sent as a high half-bit followed by a low half-bit, and a 0 is sent as low then high. The line is oversampled by a fast system clock through a two-flop synchronizer. The decoder does not look at which way the mid-bit edge goes. Each transition that it accepts as a mid-bit edge starts a countdown of three quarters of a bit period. When the countdown ends, the decoder captures the synchronized line. At that moment the line is in the first half of the following bit, so the captured level is that bit's value. Edges that arrive while the countdown is running are ignored. This is how the bit-boundary edges are rejected.

A controller is built around three named states. `HUNT` waits for a sync bit. `TIMING` is active while the countdown runs. `ARMED` waits for the next mid-bit edge. The transitions are:

- *sync-accept* (`HUNT`→`TIMING`): taken on the first transition seen while hunting.
- *expire-capture* (`TIMING`→`ARMED`): taken when the countdown ends.
- *mid-edge* (`ARMED`→`TIMING`): taken on any transition while armed.
- *silence-drop* (`ARMED`→`HUNT`): taken when no transition has arrived for two bit periods.

The first transition is the mid edge of a sync bit. The line level just before that edge sets the output polarity. Captured bits are shifted into bytes, most significant bit first. Bytes keep coming without a new sync bit until the line goes silent.

Top module: `mcode_rx`

## Requirements
- R1: While reset is asserted and afterwards, until the first capture, `ser_data`, `word_out` and `word_valid` are 0, and `rec_clk` follows the synchronized line (0 on an idle-low line).
- R2: In `HUNT`, the first transition is taken as the sync bit's mid edge. The sync bit itself is never delivered. A low level before that edge (sync bit 0) selects true polarity.
- R3: Each accepted transition starts a countdown of floor(3·`BIT_CLKS`/4) system clocks. When it ends, the synchronized line is captured, and that level is the next bit. The edge direction plays no part, so `ser_data` shows each payload bit (1 = high first half) before that bit ends.
- R4: Transitions that arrive while the countdown runs are ignored. Runs of equal bits (0xFF, 0x00) therefore decode correctly despite their boundary edges.
- R5: Captured bits are assembled most significant bit first. After every 8th capture, `word_out` takes the byte and `word_valid` is high for exactly one cycle. `word_out` holds its value otherwise.
- R6: After one sync bit, consecutive bytes are delivered in order with no further sync bit.
- R7: `rec_clk` equals the raw captured bit XOR the synchronized line. It equals `ser_data` XOR polarity XOR the line delayed by two clocks.
- R8: If the line is high before the sync edge (sync bit 1), every delivered bit is inverted, on `ser_data` and in `word_out`.
- R9: In `ARMED`, if two bit periods pass with no accepted transition, the decoder returns to `HUNT`. A partial byte is then discarded: no strobe is raised and `word_out` keeps its old value.
- R10: The input goes through two flip-flops before edge detection and capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oversampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | 1 | Manchester-coded line |
| ser_data | output | 1 | Decoded serial bit, polarity applied |
| rec_clk | output | 1 | Recovered clock: raw captured bit XOR synchronized line |
| word_out | output | WORD_BITS | Last completed byte |
| word_valid | output | 1 | One-cycle strobe when `word_out` updates |

## Verification
The bench goes after several corner cases, each tied to a specific failure.

- **Equal-bit runs (0xFF, 0x00).** A decoder that accepted edges during the countdown would lock onto bit boundaries and return inverted or shifted bytes.
- **Sample point.** `ser_data` is checked at the last clock of every payload bit. A delay that ran past the half-bit mark would capture second halves and show inverted bits.
- **Mid-byte silence.** A partial byte is followed by silence. A decoder that did not return to hunting, or did not clear its bit counter, would raise a stray strobe or misalign the next byte.
- **Sync bit 1.** A frame that starts with a 1 checks that the inversion covers both outputs.

`rec_clk` is compared every cycle against the line history that the bench keeps itself.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_TIMING = 2'd1,
        ST_ARMED  = 2'd2
    } rx_state_e;
endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line,
    output logic line_prev,
    output logic toggled
);
    // chain[STAGES-1] is the synchronized line; chain[STAGES] is one cycle older.
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign line      = chain[STAGES-1];
    assign line_prev = chain[STAGES];
    assign toggled   = line ^ line_prev;
endmodule

// File: rtl/mdec_timer.sv
module mdec_timer #(
    parameter int DELAY_CLKS   = 12,
    parameter int SILENCE_CLKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic track,
    output logic expire,
    output logic busy,
    output logic silent
);
    localparam int CW = $clog2(SILENCE_CLKS + 1);
    localparam logic [CW-1:0] DLOAD = CW'(DELAY_CLKS - 1);
    localparam logic [CW-1:0] SMAX  = CW'(SILENCE_CLKS);

    logic [CW-1:0] dcnt;
    logic [CW-1:0] scnt;
    logic          run;

    // Countdown from an accepted edge to the capture point.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run  <= 1'b0;
            dcnt <= '0;
        end else if (start) begin
            run  <= 1'b1;
            dcnt <= DLOAD;
        end else if (run) begin
            if (dcnt == '0) run  <= 1'b0;
            else            dcnt <= dcnt - 1'b1;
        end
    end

    // Cycles since the last accepted edge, saturating at the silence limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                scnt <= '0;
        else if (!track || start)  scnt <= '0;
        else if (scnt != SMAX)     scnt <= scnt + 1'b1;
    end

    assign expire = run && (dcnt == '0);
    assign busy   = run;
    assign silent = (scnt == SMAX);

    // R4: a running countdown steps down by one each cycle unless restarted.
    a_r4_countdown_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && dcnt != '0) |=> (run && dcnt == $past(dcnt) - 1'b1));
endmodule

// File: rtl/mdec_shift.sv
module mdec_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         valid
);
    localparam int CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

    logic [W-1:0]    sh;
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            cnt   <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (load) begin
                sh <= {sh[W-2:0], bit_in};
                if (cnt == LAST) begin
                    cnt   <= '0;
                    word  <= {sh[W-2:0], bit_in};
                    valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5: strobe lasts one cycle; word only moves together with the strobe.
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));
endmodule

// File: rtl/mcode_rx.sv
module mcode_rx
    import mdec_pkg::*;
#(
    parameter int BIT_CLKS  = 16,
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 code_in,
    output logic                 ser_data,
    output logic                 rec_clk,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_valid
);
    localparam int DELAY_CLKS   = (3 * BIT_CLKS) / 4;
    localparam int SILENCE_CLKS = 2 * BIT_CLKS;

    rx_state_e state_q, state_d;
    logic line, line_prev, edge_seen;
    logic tmr_expire, tmr_busy, tmr_silent;
    logic start_tmr, take_sync, do_cap, drop;
    logic cap_q, pol_q;

    mdec_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(code_in),
        .line(line), .line_prev(line_prev), .toggled(edge_seen)
    );

    mdec_timer #(.DELAY_CLKS(DELAY_CLKS), .SILENCE_CLKS(SILENCE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_tmr),
        .track(state_q != ST_HUNT),
        .expire(tmr_expire), .busy(tmr_busy), .silent(tmr_silent)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (edge_seen) state_d = ST_TIMING;
            ST_TIMING: if (tmr_expire) state_d = ST_ARMED;
            ST_ARMED: begin
                if (edge_seen)       state_d = ST_TIMING;
                else if (tmr_silent) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // Per-state strobes.
    always_comb begin
        take_sync = (state_q == ST_HUNT) && edge_seen;
        start_tmr = edge_seen && ((state_q == ST_HUNT) || (state_q == ST_ARMED));
        do_cap    = (state_q == ST_TIMING) && tmr_expire;
        drop      = (state_q == ST_ARMED) && !edge_seen && tmr_silent;
    end

    // Polarity from the sync bit's first half; capture at countdown end.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            if (take_sync) pol_q <= line_prev;
            if (do_cap)    cap_q <= line;
        end
    end

    mdec_shift #(.W(WORD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .clear(drop || take_sync), .load(do_cap),
        .bit_in(line ^ pol_q), .word(word_out), .valid(word_valid)
    );

    assign ser_data = cap_q ^ pol_q;
    assign rec_clk  = cap_q ^ line;

    // R4: while timing, the countdown is running, so edges cannot restart it.
    a_r4_timing_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMING) |-> tmr_busy);
    // R3: the captured bit only changes right after a countdown expiry.
    a_r3_capture_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        !((state_q == ST_TIMING) && tmr_expire) |=> $stable(cap_q));
    // R9: silence while armed sends the decoder back to hunting.
    a_r9_silence_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ARMED) && tmr_silent && !edge_seen) |=> (state_q == ST_HUNT));
    // R9: no byte is completed while hunting.
    a_r9_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |-> !word_valid);
endmodule

// File: tb/sim_mcode_rx.sv
module sim_mcode_rx;
    localparam int BITC = 16;
    localparam int HALF = BITC / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic ser_data, rec_clk, word_valid;
    logic [7:0] word_out;

    mcode_rx #(.BIT_CLKS(BITC), .WORD_BITS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .code_in(din), .ser_data(ser_data),
        .rec_clk(rec_clk), .word_out(word_out), .word_valid(word_valid)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic pol_exp = 1'b0;
    logic chk_en = 1'b0;
    logic [1:0] hist = 2'b00;
    logic [7:0] exp_q[$];
    logic [7:0] e_word;

    // Line as applied at the last two rising edges: hist[1] is the synchronized line.
    always @(posedge clk) hist <= {hist[0], din};

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Reference comparison on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (chk_en)
                check(rec_clk == (ser_data ^ pol_exp ^ hist[1]), "R7 rec_clk",
                      rec_clk, ser_data ^ pol_exp ^ hist[1]);
            if (word_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected strobe", word_out, 0);
                end else begin
                    e_word = exp_q.pop_front();
                    check(word_out == e_word, "R5 R6 byte", word_out, e_word);
                end
            end
        end
    end

    // One Manchester bit: first half = value, second half = inverse.
    task automatic send_bit(input logic b, input bit chk);
        for (int i = 0; i < BITC; i++) begin
            @(negedge clk);
            if (chk && i == BITC - 1)
                check(ser_data == (b ^ pol_exp), "R3 R10 ser_data", ser_data, b ^ pol_exp);
            din = (i < HALF) ? b : ~b;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        exp_q.push_back(v ^ {8{pol_exp}});
        for (int i = 7; i >= 0; i--) send_bit(v[i], 1'b1);
    endtask

    task automatic start_frame(input logic s);
        pol_exp = s;
        send_bit(s, 1'b0);
        chk_en = 1'b1;
    endtask

    task automatic end_frame();
        chk_en = 1'b0;
        @(negedge clk);
        din = 1'b0;
        repeat (4 * BITC) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        din = 1'b0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(word_valid == 1'b0, "R1 reset valid", word_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_data == 1'b0, "R1 ser_data", ser_data, 0);
        check(rec_clk == 1'b0, "R1 rec_clk", rec_clk, 0);
        check(word_out == 8'h00, "R1 word_out", word_out, 0);
        check(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
        repeat (3 * BITC) @(negedge clk);

        // R2: sync 0 then one byte.
        start_frame(1'b0);
        send_byte(8'h34);
        end_frame();
        check(word_out == 8'h34, "R2 sync consumed", word_out, 8'h34);

        // R4 R6: continuous bytes with equal-bit runs.
        start_frame(1'b0);
        send_byte(8'hA5);
        send_byte(8'hFF);
        send_byte(8'h00);
        send_byte(8'h0F);
        end_frame();
        check(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
        check(word_out == 8'h0F, "R4 last byte", word_out, 8'h0F);

        // R9: partial byte then silence, then a fresh frame.
        start_frame(1'b0);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        chk_en = 1'b0;
        repeat (4 * BITC) @(negedge clk);
        check(word_out == 8'h0F, "R9 partial discarded", word_out, 8'h0F);
        start_frame(1'b0);
        send_byte(8'h34);
        end_frame();
        check(word_out == 8'h34, "R9 resync", word_out, 8'h34);

        // R8: line idles high (spurious edge times out), then sync 1.
        @(negedge clk);
        din = 1'b1;
        repeat (4 * BITC) @(negedge clk);
        start_frame(1'b1);
        send_byte(8'h5C);
        end_frame();
        check(word_out == 8'hA3, "R8 inverted byte", word_out, 8'hA3);

        check(exp_q.size() == 0, "R5 no missing strobe", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule